// File: doc/BRIEF.md
# ADC Conversion Sequencer with Automatic Offset Correction

This block runs the timing of a sixteen-channel analog-to-digital converter. Its clock is the already prescaled converter clock. A start pulse latches a 16-bit channel mask and an offset-correction enable. The block then walks a channel index in a rotated order, beginning at the reference channel (15) and going on through 0, 1, and so on up to 14. For every channel in the mask it opens a sample window and then a conversion window toward an external successive-approximation core.

On the last cycle of each conversion window the raw code from the core is captured, provided the core flags it as valid. With correction enabled, channel 15 selected and at least one other channel selected, channel 15 is converted first. It is a trimmed reference whose ideal code is 8. Its deviation from 8 is removed from every other result, and the corrected value is clamped to the code range. Results go to per-channel registers that are read through an index port, and a completion flag reports the end of the sequence.

While a channel converts, the search for the next selected channel runs alongside, so no counting cycles are spent between channels apart from a fixed short gap.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy, done, sample_en and conv_strobe are 0, and every result register reads 0.
- R2: The scan visits positions 0..15, mapped to channels 15, 0, 1, …, 14. Each step costs one cycle, so the first selected channel at position p starts sampling p+1 cycles after the start edge. conv_chan shows that channel during its sample and strobe cycles.
- R3: For each selected channel, sample_en is high for exactly 9 cycles. conv_strobe follows for one cycle as the first of 18 conversion cycles.
- R4: A sequence holding only channel 10 raises done at the 39th rising edge after the edge that accepted start.
- R5: Consecutive selected channels are separated by exactly 4 idle cycles between the end of one conversion and the next sample window, whatever their distance in the scan. Channels 15 and 10 together finish at edge 59.
- R6: On the final conversion cycle the raw code is written to the converting channel's result register only when raw_valid is 1. Otherwise that register keeps its old value.
- R7: With ofs_en=1, channel 15 selected and at least one other channel selected, each other channel stores raw − (raw15 − 8). Channel 15 stores its raw code.
- R8: With ofs_en=0, or with channel 15 not selected, every channel stores its raw code unchanged.
- R9: A corrected value below 0 is stored as 0, and one above 1023 is stored as 1023.
- R10: A start pulse while busy is 1 is ignored. The running sequence's timing and the mask in use are unaffected.
- R11: done rises when the last conversion ends and stays set until a done_clr pulse or an accepted start clears it. An empty mask scans all 16 positions and raises done at edge 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| chan_mask | input | 16 | Channel select mask, bit n selects channel n |
| ofs_en | input | 1 | Offset correction enable, latched at start |
| done_clr | input | 1 | Clears the completion flag |
| raw_data | input | 10 | Raw code from the converter core |
| raw_valid | input | 1 | Raw code valid, checked on the last conversion cycle |
| rd_chan | input | 4 | Result read index |
| sample_en | output | 1 | High throughout the sample window |
| conv_strobe | output | 1 | One-cycle strobe opening the conversion window |
| conv_chan | output | 4 | Channel currently addressed |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence-complete flag |
| rd_data | output | 10 | Stored result of channel rd_chan |

## Verification
The bench keeps a queue of expected cycles for each accepted start and compares sample_en, conv_strobe, conv_chan, busy and done on every cycle, at the falling edge. At that point the registered outputs from the preceding rising edge have settled. The state after edge k is predicted from the start edge: p+1 scan cycles, then 9 sample cycles, 18 conversion cycles and 4 gap cycles per further channel. done is therefore due exactly at edge p+1+27n+4(n−1), and this count is also checked directly. Result registers are written on the same edge as the last conversion cycle. They are read back through rd_chan only after done is seen, and the bench compares them with values it computes itself from the raw table, the reference correction and the clamp.

// File: rtl/adcseq_pkg.sv
// Package: shared state type for the conversion sequencer.
// Assumes nothing beyond a single clock domain.
package adcseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SAMP,
        ST_CONV,
        ST_GAP
    } seq_st_e;
endpackage

// File: rtl/adcseq_pick.sv
// Next-channel finder: returns the lowest scan position above cur whose
// select bit is set. Purely combinational; used to overlap the search
// for the next channel with the running conversion.
module adcseq_pick #(
    parameter int NCH = 16,
    localparam int PW = $clog2(NCH)
) (
    input  logic [NCH-1:0] sel,
    input  logic [PW-1:0]  cur,
    output logic           found,
    output logic [PW-1:0]  nxt
);
    logic [NCH-1:0] above;

    // Qualify each position with "lies after the current position".
    for (genvar i = 0; i < NCH; i++) begin : g_above
        assign above[i] = sel[i] && (PW'(i) > cur);
    end

    // Priority pick of the lowest qualified position.
    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (above[i]) begin
                found = 1'b1;
                nxt   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/adcseq_fix.sv
// Offset corrector: removes (ref_raw - REF_CODE) from raw when apply is
// set and clamps the result to [0, 2^DW-1]. Combinational.
module adcseq_fix #(
    parameter int DW       = 10,
    parameter int REF_CODE = 8,
    localparam int XW = DW + 2
) (
    input  logic          apply,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] ref_raw,
    output logic [DW-1:0] corr
);
    logic signed [XW-1:0] diff;

    // Signed difference with reference deviation removed, then clamp.
    always_comb begin
        diff = XW'(raw) + XW'(REF_CODE) - XW'(ref_raw);
        if (!apply) begin
            corr = raw;
        end else if (diff[XW-1]) begin
            corr = '0;
        end else if (diff[XW-2:DW] != '0) begin
            corr = '1;
        end else begin
            corr = diff[DW-1:0];
        end
    end

    // A reference at or below its ideal code must never lower a result.
    always_comb begin
        if (apply && (ref_raw <= DW'(REF_CODE))) begin
            p_lowref_noloss_r9: assert (corr >= raw);
        end
    end
endmodule

// File: rtl/adcseq_bank.sv
// Result register bank: one DW-bit register per channel, written on
// wr_en, read combinationally by index. Synchronous active-low reset.
module adcseq_bank #(
    parameter int NCH = 16,
    parameter int DW  = 10,
    localparam int PW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ch,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ch,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        // Hold channel i's latest accepted result.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_ch == PW'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Index read port.
    assign rd_data = regs[rd_ch];
endmodule

// File: rtl/adc_seq_top.sv
// Conversion sequencer top. Runs on the prescaled converter clock.
// Scans positions 0..NCH-1 (channel NCH-1 first, then 0..NCH-2), one cycle
// per step, then per selected channel: SAMP_CYC sample cycles, CONV_CYC
// conversion cycles, GAP_CYC idle cycles before the next one. The next
// channel is found during the conversion, so no further scan cycles occur.
// Assumes the converter core presents its code with raw_valid on the last
// conversion cycle.
module adc_seq_top #(
    parameter int NCH      = 16,
    parameter int DW       = 10,
    parameter int SAMP_CYC = 9,
    parameter int CONV_CYC = 18,
    parameter int GAP_CYC  = 4,
    parameter int REF_CODE = 8,
    localparam int PW = $clog2(NCH),
    localparam int CW = $clog2(SAMP_CYC + CONV_CYC + GAP_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NCH-1:0] chan_mask,
    input  logic           ofs_en,
    input  logic           done_clr,
    input  logic [DW-1:0]  raw_data,
    input  logic           raw_valid,
    input  logic [PW-1:0]  rd_chan,
    output logic           sample_en,
    output logic           conv_strobe,
    output logic [PW-1:0]  conv_chan,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  rd_data
);
    import adcseq_pkg::*;

    localparam logic [PW-1:0] REF_CH = PW'(NCH - 1);

    seq_st_e        st;
    logic [PW-1:0]  pos;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] sel_q;
    logic [NCH-1:0] sel_rot;
    logic           comp_q;
    logic [DW-1:0]  ref_q;
    logic           nx_found;
    logic [PW-1:0]  nx_pos;
    logic           capture;
    logic [DW-1:0]  corr;

    // Map a scan position to its channel number.
    function automatic logic [PW-1:0] pos2ch(input logic [PW-1:0] p);
        return (p == '0) ? REF_CH : p - 1'b1;
    endfunction

    // Rotate the mask into scan order: position 0 is the reference channel.
    assign sel_rot[0] = chan_mask[NCH-1];
    for (genvar i = 1; i < NCH; i++) begin : g_rot
        assign sel_rot[i] = chan_mask[i-1];
    end

    adcseq_pick #(.NCH(NCH)) u_pick (
        .sel   (sel_q),
        .cur   (pos),
        .found (nx_found),
        .nxt   (nx_pos)
    );

    // Sequencer state, position, phase counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pos    <= '0;
            cnt    <= '0;
            sel_q  <= '0;
            comp_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st     <= ST_SCAN;
                        pos    <= '0;
                        sel_q  <= sel_rot;
                        comp_q <= ofs_en && chan_mask[NCH-1] && (|chan_mask[NCH-2:0]);
                        done   <= 1'b0;
                    end else if (done_clr) begin
                        done <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (sel_q[pos]) begin
                        st  <= ST_SAMP;
                        cnt <= CW'(SAMP_CYC - 1);
                    end else if (pos == PW'(NCH - 1)) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_SAMP: begin
                    if (cnt == '0) begin
                        st  <= ST_CONV;
                        cnt <= CW'(CONV_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt == '0) begin
                        if (nx_found) begin
                            st  <= ST_GAP;
                            cnt <= CW'(GAP_CYC - 1);
                        end else begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        st  <= ST_SAMP;
                        pos <= nx_pos;
                        cnt <= CW'(SAMP_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Reference code register: preset to the ideal code at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= DW'(REF_CODE);
        end else if (st == ST_IDLE && start) begin
            ref_q <= DW'(REF_CODE);
        end else if (capture && conv_chan == REF_CH) begin
            ref_q <= raw_data;
        end
    end

    // Converter-side outputs derived from state.
    assign busy        = (st != ST_IDLE);
    assign sample_en   = (st == ST_SAMP);
    assign conv_strobe = (st == ST_CONV) && (cnt == CW'(CONV_CYC - 1));
    assign conv_chan   = pos2ch(pos);
    assign capture     = (st == ST_CONV) && (cnt == '0) && raw_valid;

    adcseq_fix #(.DW(DW), .REF_CODE(REF_CODE)) u_fix (
        .apply   (comp_q && (conv_chan != REF_CH)),
        .raw     (raw_data),
        .ref_raw (ref_q),
        .corr    (corr)
    );

    adcseq_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (capture),
        .wr_ch   (conv_chan),
        .wr_data (corr),
        .rd_ch   (rd_chan),
        .rd_data (rd_data)
    );

    // Conversion strobe always directly follows a sample window.
    p_strobe_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $past(sample_en));

    // The conversion strobe lasts a single cycle.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);

    // The addressed channel holds still through a sample window.
    p_sample_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(sample_en)) |-> $stable(conv_chan));

    // A start while running leaves the latched selection untouched.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sel_q));

    // Completion is only reported while idle.
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sim_adc_seq_top.sv
// Bench: behavioural per-cycle model (queue of expected cycles) compared
// at every falling edge; results checked after completion.
module sim_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] chan_mask = '0;
    logic        ofs_en = 1'b0;
    logic        done_clr = 1'b0;
    logic [9:0]  raw_data;
    logic        raw_valid;
    logic [3:0]  rd_chan = '0;
    logic        sample_en, conv_strobe, busy, done;
    logic [3:0]  conv_chan;
    logic [9:0]  rd_data;

    int  checks = 0;
    int  errors = 0;
    int  q[$];
    bit  done_m = 1'b0;
    int  res_m[16];
    int  raw_tab[16];
    bit  vknob = 1'b1;

    always #5 clk = ~clk;

    assign raw_data  = 10'(raw_tab[conv_chan]);
    assign raw_valid = vknob;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
        .ofs_en(ofs_en), .done_clr(done_clr), .raw_data(raw_data),
        .raw_valid(raw_valid), .rd_chan(rd_chan), .sample_en(sample_en),
        .conv_strobe(conv_strobe), .conv_chan(conv_chan), .busy(busy),
        .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected cycle list and result values for an accepted start.
    task automatic build(input logic [15:0] m, input bit oe);
        int chs[$];
        bit comp;
        for (int p = 0; p < 16; p++) begin
            int c = (p == 0) ? 15 : p - 1;
            if (m[c]) chs.push_back(c);
        end
        if (chs.size() == 0) begin
            for (int k = 0; k < 16; k++) q.push_back(0);
        end else begin
            int p0 = (chs[0] == 15) ? 0 : chs[0] + 1;
            for (int k = 0; k <= p0; k++) q.push_back(0);
            foreach (chs[i]) begin
                if (i > 0) for (int k = 0; k < 4; k++) q.push_back(0);
                for (int k = 0; k < 9; k++) q.push_back(chs[i] * 4 + 2);
                q.push_back(chs[i] * 4 + 1);
                for (int k = 0; k < 17; k++) q.push_back(0);
            end
        end
        comp = oe && m[15] && (m[14:0] != 0);
        if (vknob) begin
            foreach (chs[i]) begin
                int v = raw_tab[chs[i]];
                if (comp && chs[i] != 15) v = v - (raw_tab[15] - 8);
                if (v < 0) v = 0;
                if (v > 1023) v = 1023;
                res_m[chs[i]] = v;
            end
        end
    endtask

    // One cycle: compare against model, drive inputs, advance model.
    task automatic tick(input bit st, input bit clr, input logic [15:0] m, input bit oe);
        @(negedge clk);
        begin
            bit b = (q.size() > 0);
            int f = b ? q[0] : 0;
            chk(busy == b, "R11 busy", busy, b);
            chk(done == done_m, "R11 done", done, done_m);
            chk(sample_en == f[1], "R3 sample_en", sample_en, f[1]);
            chk(conv_strobe == f[0], "R3 conv_strobe", conv_strobe, f[0]);
            if (f[1:0] != 0) chk(conv_chan == 4'(f / 4), "R2 conv_chan", conv_chan, f / 4);
        end
        start = st; done_clr = clr; chan_mask = m; ofs_en = oe;
        if (q.size() > 0) begin
            void'(q.pop_front());
            if (q.size() == 0) done_m = 1'b1;
        end else if (st) begin
            build(m, oe);
            done_m = 1'b0;
        end else if (clr) begin
            done_m = 1'b0;
        end
        @(posedge clk);
    endtask

    task automatic check_results(input string req);
        for (int c = 0; c < 16; c++) begin
            tick(0, 0, '0, 0);
            rd_chan = 4'(c);
            #1;
            chk(rd_data == 10'(res_m[c]), req, rd_data, res_m[c]);
        end
    endtask

    // Run a sequence; optionally inject a start with mask m2 at tick inj.
    task automatic run(input logic [15:0] m, input bit oe, input int inj,
                       input logic [15:0] m2, input string req);
        int n = 0, p0 = -1, want, cyc = 0;
        for (int p = 0; p < 16; p++) begin
            int c = (p == 0) ? 15 : p - 1;
            if (m[c]) begin
                n++;
                if (p0 < 0) p0 = p;
            end
        end
        want = (n == 0) ? 16 : p0 + 1 + 27 * n + 4 * (n - 1);
        tick(1, 0, m, oe);
        for (int k = 1; k < 3000; k++) begin
            if (k == inj) tick(1, 0, m2, oe);
            else          tick(0, 0, m, oe);
            cyc = k;
            #1;
            if (done) break;
        end
        chk(cyc == want, {req, " cycles to done"}, cyc, want);
        check_results(req);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (res_m[i]) res_m[i] = 0;
        foreach (raw_tab[i]) raw_tab[i] = 100 + 37 * i;
        raw_tab[15] = 13;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tick(0, 0, '0, 0);
        chk(!busy && !done && !sample_en && !conv_strobe, "R1 reset outputs",
            {busy, done, sample_en, conv_strobe}, 0);
        check_results("R1 reset results");

        run(16'h0400, 0, -1, '0, "R4 ch10 only");
        run(16'h8400, 1, -1, '0, "R5 R7 ch15+ch10 corrected");
        run(16'h0001, 0, -1, '0, "R2 ch0 only");
        run(16'h4000, 0, -1, '0, "R2 ch14 only");

        raw_tab[15] = 20; raw_tab[0] = 5; raw_tab[3] = 500;
        run(16'hC009, 1, -1, '0, "R9 clamp low and R5 gaps");
        raw_tab[15] = 2; raw_tab[3] = 1020;
        run(16'h8008, 1, -1, '0, "R9 clamp high");

        raw_tab[5] = 640; raw_tab[7] = 222;
        run(16'h8020, 0, -1, '0, "R8 correction off");
        run(16'h00A0, 1, -1, '0, "R8 no reference selected");

        raw_tab[8] = 777;
        run(16'h0010, 0, 20, 16'h0100, "R10 start while busy");

        vknob = 1'b0; raw_tab[5] = 11;
        run(16'h0020, 0, -1, '0, "R6 invalid raw kept");
        vknob = 1'b1;

        run(16'h0000, 0, -1, '0, "R11 empty mask");
        tick(0, 1, '0, 0);
        tick(0, 0, '0, 0);
        #1;
        chk(done == 1'b0, "R11 done_clr", done, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule